// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block models a single-port synchronous static RAM that puts read data on the bus in the same cycle its address is registered, with no output register. Write data follows its address by one clock. The block holds that late write in a small pending buffer, so reads and writes can alternate on the shared data bus on every cycle with no idle cycles between them. A read that hits a word whose write is still in the buffer sees the new bytes merged over the stored word.

A command is accepted on a rising edge only when all three chip enables are high and the sleep input is low. The load/advance control either starts a new four-beat burst at the presented address or steps the current burst. The burst order is linear or interleaved and is chosen by a static input. Words are built from 9-bit byte lanes, and each lane has its own write enable. The bidirectional data bus is split into an input, an output and a drive enable. An asynchronous output enable and an asynchronous sleep input can force the drive enable off at any time.

Top module: `ftsram_top`

## Requirements
- R1: While reset is applied and after it is released, with no command accepted, `dq_oe` is 0.
- R2: A read accepted on edge k (`adv`=0, `wr`=0) drives `dq_out` with the word at that address, and sets `dq_oe` to 1, during the cycle that follows edge k, before edge k+1.
- R3: A write accepted on edge k takes its data from `dq_in` on edge k+1. Byte lane i is bits [9i+8:9i]. Only lanes whose `byte_we` bit was 1 on edge k change, and the other lanes keep their old contents.
- R4: During the cycle after a write command or a write burst beat is accepted, `dq_oe` is 0.
- R5: A read issued on the edge that captures a write's data, to that write's address, returns the stored word with the pending enabled lanes replaced by the new data. Read, write and read on consecutive edges need no idle cycle.
- R6: With `interleave`=0, `adv`=1 on an edge after an accepted beat continues the burst. Beat n (n=0..3) then uses low address bits (start+n) mod 4, and the upper bits stay fixed.
- R7: With `interleave`=1, beat n of a burst uses low address bits start XOR n.
- R8: A command is accepted only when `en_a`, `en_b` and `en_c` are all 1. Otherwise the cycle is a deselect: nothing is driven and nothing is written.
- R9: `out_en`=0 forces `dq_oe` to 0 at once, without waiting for a clock edge. Setting it back to 1 restores the read drive in the same cycle.
- R10: While `sleep`=1, `dq_oe` is 0 at once and every command is ignored, including writes.
- R11: `adv`=1 on an edge that follows no accepted beat is treated as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address, used when a burst is loaded |
| adv | input | 1 | 1 steps the current burst, 0 loads a new one |
| wr | input | 1 | 1 write, 0 read (sampled on load) |
| byte_we | input | LANES | Per-lane write enables, sampled with each write beat |
| en_a | input | 1 | Chip enable, active high |
| en_b | input | 1 | Chip enable, active high |
| en_c | input | 1 | Chip enable, active high |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous power-down, active high |
| dq_in | input | LANES*9 | Data bus, inbound side |
| dq_out | output | LANES*9 | Data bus, outbound side |
| dq_oe | output | 1 | Drive enable for the outbound side |

## Verification
The hardest case to reach is a read that lands on the edge where a write's late data is captured, because only then does the word sit in the pending buffer instead of the array. The bench reaches it by issuing a read, a partial-lane write and a read to the same address on three consecutive edges, using alternating lane masks. It then reads the address once more, after the commit. Full-array sweeps with rotating burst start offsets cover the wrap in both burst orders. Every disallowed enable pattern, and writes issued during sleep, are each followed by a read of the target word, which shows at the ports that the word did not change.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;

    localparam int LANE_W = 9;
    localparam int BURST_LEN = 4;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // low address bits of a burst beat
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/ftsram_burst.sv
module ftsram_burst #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    beat,
    input  logic          ilv,
    output logic [AW-1:0] eaddr
);
    import ftsram_pkg::*;

    always_comb begin
        eaddr      = base;
        eaddr[1:0] = beat_low(base[1:0], beat, ilv);
    end
endmodule

// File: rtl/ftsram_merge.sv
module ftsram_merge #(
    parameter int LANES = 2,
    localparam int W = LANES * ftsram_pkg::LANE_W
) (
    input  logic [W-1:0]     old_word,
    input  logic [W-1:0]     new_word,
    input  logic [LANES-1:0] take_new,
    output logic [W-1:0]     merged
);
    import ftsram_pkg::*;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = take_new[l] ? new_word[l*LANE_W +: LANE_W]
                                                        : old_word[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/ftsram_array.sv
module ftsram_array #(
    parameter int DEPTH = 64,
    parameter int LANES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int W  = LANES * ftsram_pkg::LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wbe,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rdata
);
    import ftsram_pkg::*;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wbe[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ftsram_top.sv
module ftsram_top #(
    parameter int DEPTH = 64,
    parameter int LANES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int W  = LANES * ftsram_pkg::LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             adv,
    input  logic             wr,
    input  logic [LANES-1:0] byte_we,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             en_c,
    input  logic             interleave,
    input  logic             out_en,
    input  logic             sleep,
    input  logic [W-1:0]     dq_in,
    output logic [W-1:0]     dq_out,
    output logic             dq_oe
);
    import ftsram_pkg::*;

    typedef struct packed {
        logic             act;    // a beat was accepted on the last edge
        op_e              op;
        logic [AW-1:0]    base;
        logic [1:0]       beat;
        logic [LANES-1:0] be;
        logic             pv;     // pending write waiting for commit
        logic [AW-1:0]    paddr;
        logic [LANES-1:0] pbe;
        logic [W-1:0]     pdata;
    } state_t;

    state_t st_d, st_q;

    logic [AW-1:0]    eaddr;
    logic [W-1:0]     arr_rdata;
    logic [LANES-1:0] fwd_lanes;
    logic             accept;

    ftsram_burst #(.AW(AW)) u_burst (
        .base  (st_q.base),
        .beat  (st_q.beat),
        .ilv   (interleave),
        .eaddr (eaddr)
    );

    ftsram_array #(.DEPTH(DEPTH), .LANES(LANES)) u_array (
        .clk   (clk),
        .we    (st_q.pv),
        .waddr (st_q.paddr),
        .wbe   (st_q.pbe),
        .wdata (st_q.pdata),
        .raddr (eaddr),
        .rdata (arr_rdata)
    );

    assign fwd_lanes = (st_q.pv && st_q.paddr == eaddr) ? st_q.pbe : '0;

    ftsram_merge #(.LANES(LANES)) u_merge (
        .old_word (arr_rdata),
        .new_word (st_q.pdata),
        .take_new (fwd_lanes),
        .merged   (dq_out)
    );

    assign accept = !sleep && en_a && en_b && en_c;
    assign dq_oe  = st_q.act && st_q.op == OP_READ && out_en && !sleep;

    always_comb begin
        st_d = st_q;
        // late data of the beat registered on the previous edge
        st_d.pv = st_q.act && st_q.op == OP_WRITE;
        if (st_q.act && st_q.op == OP_WRITE) begin
            st_d.paddr = eaddr;
            st_d.pbe   = st_q.be;
            st_d.pdata = dq_in;
        end
        // command decode
        if (accept && !adv) begin
            st_d.act  = 1'b1;
            st_d.op   = wr ? OP_WRITE : OP_READ;
            st_d.base = addr;
            st_d.beat = 2'd0;
            st_d.be   = byte_we;
        end else if (accept && adv && st_q.act) begin
            st_d.beat = st_q.beat + 2'd1;
            st_d.be   = byte_we;
        end else begin
            st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ftsram_checker.sv
module ftsram_checker (
    input logic clk,
    input logic rst_n,
    input logic adv,
    input logic wr,
    input logic en_a,
    input logic en_b,
    input logic en_c,
    input logic out_en,
    input logic sleep,
    input logic dq_oe
);
    logic all_en;
    assign all_en = en_a && en_b && en_c;

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !dq_oe);

    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(all_en && !sleep && !adv && !wr) && out_en && !sleep) |-> dq_oe);

    p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(all_en && !sleep && !adv && wr) |-> !dq_oe);

    p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!all_en) |-> !dq_oe);

    p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n) !out_en |-> !dq_oe);

    p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !dq_oe);
endmodule

bind ftsram_top ftsram_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .wr     (wr),
    .en_a   (en_a),
    .en_b   (en_b),
    .en_c   (en_c),
    .out_en (out_en),
    .sleep  (sleep),
    .dq_oe  (dq_oe)
);

// File: tb/tb_ftsram_top.sv
module tb_ftsram_top;
    localparam int DEPTH = 64;
    localparam int LANES = 2;
    localparam int AW = $clog2(DEPTH);
    localparam int W  = LANES * 9;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] addr = '0;
    logic adv = 0, wr = 0, en_a = 0, en_b = 0, en_c = 0;
    logic interleave = 0, out_en = 1, sleep = 0;
    logic [LANES-1:0] byte_we = '0;
    logic [W-1:0] dq_in = '0;
    logic [W-1:0] dq_out;
    logic dq_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    ftsram_top #(.DEPTH(DEPTH), .LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adv(adv), .wr(wr), .byte_we(byte_we),
        .en_a(en_a), .en_b(en_b), .en_c(en_c), .interleave(interleave), .out_en(out_en),
        .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #4 clk = ~clk;

    // bench model
    logic [W-1:0] mdl [DEPTH];
    bit m_act = 0, m_wr = 0, m_pv = 0, m_rd = 0;
    logic [AW-1:0] m_base = '0, m_paddr = '0;
    logic [1:0] m_beat = '0;
    logic [LANES-1:0] m_pbe = '0;
    logic [W-1:0] m_exp = '0;
    int salt = 0;

    function automatic logic [W-1:0] pat(input logic [AW-1:0] a);
        return W'((int'(a) * 1237 + salt * 311 + 17) ^ 18'h2A5A5);
    endfunction

    function automatic logic [W-1:0] pend_data();
        return pat(m_paddr);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ad, input logic [AW-1:0] a, input logic w,
                        input logic [LANES-1:0] be, input logic [2:0] en,
                        input logic [W-1:0] din, input string tag);
        logic [AW-1:0] ea;
        adv = ad; addr = a; wr = w; byte_we = be;
        {en_a, en_b, en_c} = en; dq_in = din;
        if (m_pv)
            for (int l = 0; l < LANES; l++)
                if (m_pbe[l]) mdl[m_paddr][l*9 +: 9] = din[l*9 +: 9];
        m_pv = 0; m_rd = 0;
        if (!sleep && en == 3'b111 && !ad) begin
            m_act = 1; m_wr = w; m_base = a; m_beat = 0;
        end else if (!sleep && en == 3'b111 && ad && m_act) begin
            m_beat = m_beat + 2'd1;
        end else m_act = 0;
        if (m_act) begin
            ea = m_base;
            ea[1:0] = interleave ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
            if (m_wr) begin m_pv = 1; m_paddr = ea; m_pbe = be; end
            else begin m_rd = 1; m_exp = mdl[ea]; end
        end
        @(posedge clk); #2;
        if (m_rd && out_en && !sleep)
            chk(dq_oe === 1'b1 && dq_out === m_exp, tag, {dq_oe, dq_out}, {1'b1, m_exp});
        else
            chk(dq_oe === 1'b0, (m_act && m_wr) ? "R4" : tag, {dq_oe, dq_out}, {1'b0, dq_out});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(dq_oe === 1'b0, "R1", {dq_oe, dq_out}, '0);
        rst_n = 1;
        step(0, 0, 0, 0, 3'b000, 0, "R1");

        // R6: fill the array with linear write bursts at rotating start offsets
        interleave = 0;
        for (int g = 0; g < DEPTH / 4; g++)
            for (int n = 0; n < 4; n++)
                step(n != 0, AW'(g * 4 + g % 4), 1, 2'b11, 3'b111, pend_data(), "R6");
        step(0, 0, 0, 0, 3'b000, pend_data(), "R8");

        // R7: interleaved read bursts
        interleave = 1;
        for (int g = 0; g < DEPTH / 4; g++)
            for (int n = 0; n < 4; n++)
                step(n != 0, AW'(g * 4 + (g + 1) % 4), 0, 0, 3'b111, 0, "R7");
        // R6: linear read bursts with wrap
        interleave = 0;
        for (int g = 0; g < DEPTH / 4; g++)
            for (int n = 0; n < 4; n++)
                step(n != 0, AW'(g * 4 + 3 - g % 4), 0, 0, 3'b111, 0, "R6");
        // R2: single reads
        for (int a = 0; a < 8; a++) step(0, AW'(a * 5), 0, 0, 3'b111, 0, "R2");

        // R3: partial lane writes then read back
        salt = 1;
        for (int a = 0; a < 16; a++) step(0, AW'(a), 1, LANES'(a % 4), 3'b111, pend_data(), "R3");
        step(0, 0, 0, 0, 3'b000, pend_data(), "R3");
        for (int a = 0; a < 16; a++) step(0, AW'(a), 0, 0, 3'b111, 0, "R3");

        // R5: read, write, read back to back on one address
        salt = 2;
        for (int a = 20; a < 28; a++) begin
            step(0, AW'(a), 0, 0, 3'b111, 0, "R5");
            step(0, AW'(a), 1, (a % 2) ? 2'b01 : 2'b10, 3'b111, 0, "R5");
            step(0, AW'(a), 0, 0, 3'b111, pend_data(), "R5");
            step(0, AW'(a), 0, 0, 3'b111, 0, "R5");
        end

        // R8: any enable pattern other than all-high is a deselect
        salt = 3;
        for (int e = 0; e < 7; e++) begin
            step(0, 40, 1, 2'b11, 3'(e), 0, "R8");
            step(0, 0, 0, 0, 3'b000, W'(18'h3FFFF - e), "R8");
            step(0, 40, 0, 0, 3'b111, 0, "R8");
        end

        // R11: advance with no burst in progress
        step(0, 0, 0, 0, 3'b000, 0, "R11");
        step(1, 12, 0, 0, 3'b111, 0, "R11");
        step(1, 12, 0, 0, 3'b111, 0, "R11");

        // R9: asynchronous output enable
        step(0, 33, 0, 0, 3'b111, 0, "R9");
        out_en = 0; #1;
        chk(dq_oe === 1'b0, "R9", {dq_oe, dq_out}, '0);
        out_en = 1; #1;
        chk(dq_oe === 1'b1 && dq_out === mdl[33], "R9", {dq_oe, dq_out}, {1'b1, mdl[33]});

        // R10: sleep ignores commands and blocks the drive
        step(0, 34, 0, 0, 3'b111, 0, "R10");
        sleep = 1; #1;
        chk(dq_oe === 1'b0, "R10", {dq_oe, dq_out}, '0);
        step(0, 41, 1, 2'b11, 3'b111, 0, "R10");
        step(0, 41, 0, 0, 3'b111, W'(18'h15555), "R10");
        sleep = 0;
        step(0, 0, 0, 0, 3'b000, W'(18'h0AAAA), "R10");
        step(0, 41, 0, 0, 3'b111, 0, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule